// File: doc/BRIEF.md
# Dual-Slope Conversion Controller

This block is the digital half of a dual-slope integrating converter. It sequences an external analog integrator and zero-crossing comparator: it discharges the integrator, connects the unknown input for a fixed interval, then connects the reference of opposite polarity. It counts clocks until the comparator reports that the integrator has returned to zero. That final count is the conversion result. The result depends only on the ratio of the input to the reference, not on the RC value or the clock rate.

A single (N+1)-bit binary counter does both timing jobs. During run-up it counts comparator-high clocks until its top bit sets. That is 2^N counts, and the lower N bits wrap to zero as it happens. The same edge moves the integrator to the reference. During run-down the same counter keeps counting, so the lower N bits directly hold the run-down time. If run-down would need another 2^N counts, the result saturates and an overrange flag is raised. A conversion is started by a one-clock request pulse while the controller is idle or finished.

Top module: `dslope_ctrl`

## Requirements
- R1: After reset, `int_clear` is 1, `sel_ref` is 0, `res_valid` is 0, `result` is 0 and `overrange` is 0. The controller then waits, idle, for a request.
- R2: A `conv_req` sampled high while idle or finished starts a clear phase. `int_clear` stays 1 for exactly CLR_CYC clocks after the sampling edge, the counter is zeroed, and `sel_ref` stays 0.
- R3: In run-up, `int_clear` and `sel_ref` are both 0. The counter advances only on clocks where `cmp_hi` is 1. `sel_ref` rises on the edge at which counter bit N first becomes 1. With the comparator held high, run-up therefore lasts 2^N clocks, and every comparator-low clock lengthens it by one.
- R4: In run-down, `sel_ref` is 1 and the counter keeps advancing on comparator-high clocks. The first clock with `cmp_hi` at 0 ends the conversion, and `result` equals the number of comparator-high run-down clocks.
- R5: With an ideal integrator, which rises by Vx per run-up clock and falls by Vr per run-down clock, the result equals ceil(2^N·Vx/Vr). This lies within one count of floor(2^N·Vx/Vr).
- R6: If the comparator is still high on a run-down clock where the lower N counter bits are all ones, the conversion ends with `result` all ones and `overrange` 1. If the comparator falls on exactly that clock, `result` is all ones and `overrange` is 0.
- R7: `res_valid` is 1 for exactly one clock, on entry to the finished state. `result` and `overrange` change only at that entry and hold their values until the next one. `int_clear` is 1 and `sel_ref` is 0 while finished.
- R8: `conv_req` is ignored during the clear, run-up and run-down phases. Such a request neither restarts nor lengthens the conversion, and it does not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Start request, one clock pulse |
| cmp_hi | input | 1 | Zero-crossing comparator output, 1 while the integrator is away from zero |
| int_clear | output | 1 | Integrator discharge switch control |
| sel_ref | output | 1 | Integrator input select: 0 unknown, 1 reference |
| res_valid | output | 1 | One-clock pulse when a new result is available |
| result | output | CNT_W | Conversion result, held between conversions |
| overrange | output | 1 | Set with a saturated result when run-down overflows |

## Verification
Two events can fall on the same run-down clock: the comparator reporting zero, and the lower counter bits reaching all ones. In the first case the count is the genuine maximum. In the second it is the overflow that triggers saturation. The bench provokes both with a behavioural integrator. With Vr = 2^N, it runs Vx = 2^N−1, where the comparator falls exactly as the counter fills and the expected result is all ones without overrange. It then runs Vx = 2^N, where the comparator is still high on that clock and the expected result is all ones with overrange set. Comparator-low gaps forced into run-up, and requests injected mid-conversion, are judged by the measured phase lengths as well as by the result.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CLEAR    = 3'd1,
    ST_RUNUP    = 3'd2,
    ST_RUNDOWN  = 3'd3,
    ST_DONE     = 3'd4
  } dsc_state_e;

endpackage

// File: rtl/dsc_counter.sv
// (N+1)-bit up counter shared by run-up and run-down.
module dsc_counter #(
  parameter int CNT_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           en,
  output logic [CNT_W:0] cnt,
  output logic           wrap
);
  localparam int CW = CNT_W + 1;

  // The lower N bits carry into bit N on this clock.
  assign wrap = en && (&cnt[CNT_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && en) |=> (cnt == CW'($past(cnt) + 1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(cnt));

endmodule

// File: rtl/dsc_clear_timer.sv
// Times the integrator discharge phase.
module dsc_clear_timer #(
  parameter int CLR_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int TW = (CLR_CYC > 1) ? $clog2(CLR_CYC) : 1;

  logic [TW-1:0] tmr;

  assign last = run && (tmr == TW'(CLR_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) tmr <= '0;
    else if (!last)  tmr <= tmr + 1'b1;
  end

  p_tmr_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (tmr <= TW'(CLR_CYC - 1)));

endmodule

// File: rtl/dsc_fsm.sv
// Phase sequencer with registered control and result outputs.
module dsc_fsm
  import dsc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_req,
  input  logic             cmp_hi,
  input  logic             wrap,
  input  logic             clr_last,
  input  logic [CNT_W-1:0] cnt_low,
  output dsc_state_e       state,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             int_clear,
  output logic             sel_ref,
  output logic             res_valid,
  output logic [CNT_W-1:0] result,
  output logic             overrange
);
  dsc_state_e nxt;
  logic       finish;

  assign cnt_clr = (state == ST_CLEAR);
  assign cnt_en  = cmp_hi && ((state == ST_RUNUP) || (state == ST_RUNDOWN));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE, ST_DONE: if (conv_req) nxt = ST_CLEAR;
      ST_CLEAR:         if (clr_last) nxt = ST_RUNUP;
      ST_RUNUP:         if (wrap)     nxt = ST_RUNDOWN;
      ST_RUNDOWN:       if (!cmp_hi || wrap) nxt = ST_DONE;
      default:          nxt = ST_IDLE;
    endcase
  end

  assign finish = (state == ST_RUNDOWN) && (nxt == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      int_clear <= 1'b1;
      sel_ref   <= 1'b0;
      res_valid <= 1'b0;
      result    <= '0;
      overrange <= 1'b0;
    end else begin
      state     <= nxt;
      int_clear <= (nxt == ST_IDLE) || (nxt == ST_CLEAR) || (nxt == ST_DONE);
      sel_ref   <= (nxt == ST_RUNDOWN);
      res_valid <= finish;
      if (finish) begin
        if (!cmp_hi) begin
          result    <= cnt_low;
          overrange <= 1'b0;
        end else begin
          result    <= '1;
          overrange <= 1'b1;
        end
      end
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(result) && $stable(overrange)));

  p_saturate_r6: assert property (@(posedge clk) disable iff (rst)
    overrange |-> (&result));

  p_switch_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUNUP && wrap) |=> (state == ST_RUNDOWN && sel_ref));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUNUP || state == ST_RUNDOWN) |=> (state != ST_CLEAR));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (int_clear && !sel_ref));

endmodule

// File: rtl/dslope_ctrl.sv
// Dual-slope converter controller top.
module dslope_ctrl #(
  parameter int CNT_W   = 8,
  parameter int CLR_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_req,
  input  logic             cmp_hi,
  output logic             int_clear,
  output logic             sel_ref,
  output logic             res_valid,
  output logic [CNT_W-1:0] result,
  output logic             overrange
);
  import dsc_pkg::*;

  dsc_state_e     state;
  logic           cnt_clr;
  logic           cnt_en;
  logic [CNT_W:0] cnt;
  logic           wrap;
  logic           clr_last;

  dsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .en   (cnt_en),
    .cnt  (cnt),
    .wrap (wrap)
  );

  dsc_clear_timer #(.CLR_CYC(CLR_CYC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_CLEAR),
    .last (clr_last)
  );

  dsc_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .conv_req  (conv_req),
    .cmp_hi    (cmp_hi),
    .wrap      (wrap),
    .clr_last  (clr_last),
    .cnt_low   (cnt[CNT_W-1:0]),
    .state     (state),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .int_clear (int_clear),
    .sel_ref   (sel_ref),
    .res_valid (res_valid),
    .result    (result),
    .overrange (overrange)
  );

  p_sel_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(int_clear && sel_ref));

  p_runup_top_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUNUP) |-> !cnt[CNT_W]);

endmodule

// File: tb/test_dslope_ctrl.sv
module test_dslope_ctrl;
  localparam int CLK_P   = 10;
  localparam int N       = 8;
  localparam int CLR     = 4;
  localparam int FULL    = 1 << N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_req = 1'b0;
  logic cmp_hi;
  logic int_clear, sel_ref, res_valid, overrange;
  logic [N-1:0] result;

  int  n_chk = 0;
  int  n_fail = 0;
  int  acc = 0;
  int  vx_m = 0;
  int  vr_m = 1;
  bit  force_lo = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dslope_ctrl #(.CNT_W(N), .CLR_CYC(CLR)) i_dslope_ctrl (
    .clk(clk), .rst(rst), .conv_req(conv_req), .cmp_hi(cmp_hi),
    .int_clear(int_clear), .sel_ref(sel_ref), .res_valid(res_valid),
    .result(result), .overrange(overrange)
  );

  // Behavioural integrator and comparator.
  assign cmp_hi = !force_lo &&
                  ((!int_clear && !sel_ref && vx_m > 0) || (sel_ref && acc > 0));

  always @(posedge clk) begin
    if (int_clear)     acc <= 0;
    else if (!sel_ref) acc <= acc + vx_m;
    else               acc <= acc - vr_m;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(int_clear == 1'b1, "R1 int_clear", int_clear, 1);
    check(sel_ref == 1'b0, "R1 sel_ref", sel_ref, 0);
    check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    check(result == '0, "R1 result", result, 0);
    check(overrange == 1'b0, "R1 overrange", overrange, 0);
  endtask

  // One conversion; gap = forced comparator-low run-up clocks; poke = stray requests.
  task automatic t_convert(input int vx, input int vr, input int gap, input bit poke);
    int clr_n = 0, up_n = 0, dn_hi = 0, cyc = 0;
    int tot, k, exp_res, flo;
    bit exp_ovr, seen = 0;
    vx_m = vx; vr_m = vr;
    @(negedge clk); conv_req = 1'b1;
    @(negedge clk); conv_req = 1'b0;
    while (!seen && cyc < 5000) begin
      cyc++;
      conv_req = 1'b0;
      force_lo = 1'b0;
      if (res_valid) seen = 1;
      else if (int_clear) begin
        clr_n++;
        if (poke && clr_n == 2) conv_req = 1'b1;
      end else if (!sel_ref) begin
        up_n++;
        if (up_n >= 10 && up_n < 10 + gap) force_lo = 1'b1;
        if (poke && up_n == 20) conv_req = 1'b1;
      end else begin
        if (cmp_hi) dn_hi++;
        if (poke && dn_hi == 2) conv_req = 1'b1;
      end
      if (!seen) @(negedge clk);
    end
    conv_req = 1'b0;
    force_lo = 1'b0;
    check(seen, "R4 conversion finished", cyc, 0);
    tot = (FULL + gap) * vx;
    k = (tot + vr - 1) / vr;
    exp_ovr = (k >= FULL);
    exp_res = exp_ovr ? FULL - 1 : k;
    check(clr_n == CLR, "R2 clear length", clr_n, CLR);
    check(up_n == FULL + gap, "R3 run-up length", up_n, FULL + gap);
    check(result == exp_res, "R5 R6 result", result, exp_res);
    check(overrange == exp_ovr, "R6 overrange", overrange, exp_ovr);
    if (!exp_ovr) check(result == dn_hi, "R4 result equals run-down count", result, dn_hi);
    else          check(dn_hi == FULL, "R6 run-down count at overflow", dn_hi, FULL);
    if (!exp_ovr && gap == 0) begin
      flo = (FULL * vx) / vr;
      check(result - flo <= 1 && result >= flo, "R5 within one of floor", result, flo);
    end
    check(int_clear && !sel_ref, "R7 discharge while finished", {int_clear, sel_ref}, 2);
    @(negedge clk);
    check(res_valid == 1'b0, "R7 valid single pulse", res_valid, 0);
    if (poke) check(result == exp_res, "R8 stray request no effect", result, exp_res);
  endtask

  task automatic t_hold();
    logic [N-1:0] r0;
    logic o0;
    r0 = result; o0 = overrange;
    repeat (6) @(negedge clk);
    check(result == r0, "R7 result held", result, r0);
    check(overrange == o0, "R7 overrange held", overrange, o0);
    check(res_valid == 1'b0, "R7 no repeat valid", res_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_convert(10, 100, 0, 0);     // R5
    t_hold();                     // R7
    t_convert(37, 100, 0, 0);     // R5
    t_convert(1, 100, 0, 0);      // R5 small input
    t_convert(99, 100, 0, 0);     // R5 near top
    t_convert(50, 100, 0, 1);     // R8 stray requests
    t_convert(20, 100, 7, 0);     // R3 comparator gap in run-up
    t_convert(255, 256, 0, 0);    // R6 fall on full count
    t_convert(256, 256, 0, 0);    // R6 overflow
    t_hold();                     // R7 overrange held
    t_convert(300, 100, 0, 0);    // R6 far over
    t_convert(64, 256, 0, 0);     // R6 flag cleared, R5
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule